// File: doc/BRIEF.md
# Global-History Branch Predictor with Target Buffer

This block sits in the fetch stage and guesses the outcome of conditional branches. For each looked-up fetch address it returns one registered result a cycle later: a taken or not-taken guess, whether the target buffer held the address, the cached target, and the history value the guess was made with. The direction comes from a table of 2-bit saturating counters. The table is indexed by a global outcome history XOR-ed with address bits. The target comes from a small set-associative buffer. An address that misses in the buffer gets a static guess: taken when predecode marks the branch as backward, not taken otherwise.

When a branch resolves, the update port returns its address, outcome and target. With them it returns the history checkpoint and the guess that travelled with the branch. The block trains the counter the guess used. It allocates or refreshes a target entry for taken branches. It raises a one-cycle mispredict flag so that fetch can redirect. On a mispredict it rebuilds the history from the checkpoint plus the true outcome.

The history is updated speculatively at each accepted lookup. To keep the front end simple, a taken guess blocks the next cycle: a lookup presented in that cycle is dropped.

Top module: `brpred_top`

## Requirements
- R1: After reset, no result is valid, the stall and mispredict outputs are low, and the history is zero. Every counter holds weakly not-taken (value 1), and the target buffer is empty.
- R2: A lookup is accepted only when lk_valid and lk_br are high and lk_stall is low. Its result appears on the pr_* outputs with pr_valid high one cycle later. Any other cycle gives pr_valid low in the following cycle.
- R3: On a target-buffer hit, pr_hit is 1 and pr_target is the stored target. pr_taken is bit 1 of the counter at index history XOR lk_pc[13:2].
- R4: On a target-buffer miss, pr_hit is 0 and pr_taken equals lk_bwd (backward taken, forward not taken).
- R5: A taken result is paired with lk_stall high in the same cycle, and a lookup presented in that cycle is dropped. Not-taken results may be produced on consecutive cycles.
- R6: Each accepted lookup shifts its guess into bit 0 of the 12-bit history. pr_ghist reports the history as it was before that shift.
- R7: Each update moves the counter at index up_ghist XOR up_pc[13:2]. It counts up on taken and down on not-taken, saturating at 0 and 3.
- R8: up_mispred is high one cycle after an update exactly when up_taken differs from up_pred_tk, or when the branch was taken, hit in the buffer (up_pred_hit) and up_target differs from up_pred_tgt.
- R9: On a mispredict the history becomes {up_ghist[10:0], up_taken}. A correctly predicted update leaves it unchanged. The update has priority over a lookup in the same cycle.
- R10: Only taken updates write the target buffer. On a miss they fill the lowest-numbered empty way of the set (set = pc[6:2], tag = pc[31:7]). Not-taken updates neither allocate nor evict.
- R11: In a full 4-way set the victim is chosen by a 3-bit tree pseudo-LRU. After ways 0 to 3 are filled in order, the next allocation replaces the first one filled.
- R12: A taken update that hits in the buffer replaces the stored target with up_target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Fetch address valid |
| lk_pc | input | 32 | Fetch address |
| lk_br | input | 1 | Predecode: address holds a conditional branch |
| lk_bwd | input | 1 | Predecode: the branch jumps backward |
| lk_stall | output | 1 | Bubble cycle after a taken guess; lookups are dropped |
| pr_valid | output | 1 | Result valid |
| pr_taken | output | 1 | Guessed direction |
| pr_hit | output | 1 | Target buffer held the address |
| pr_target | output | 32 | Cached target (zero on a miss) |
| pr_ghist | output | 12 | History used for this guess (checkpoint) |
| up_valid | input | 1 | Resolved branch valid |
| up_pc | input | 32 | Resolved branch address |
| up_taken | input | 1 | Actual direction |
| up_target | input | 32 | Actual target |
| up_ghist | input | 12 | Checkpointed history returned with the branch |
| up_pred_tk | input | 1 | Direction that was guessed |
| up_pred_hit | input | 1 | Whether the guess hit in the buffer |
| up_pred_tgt | input | 32 | Target that was guessed |
| up_mispred | output | 1 | Mispredict flag, one cycle after the update |

## Verification
A lookup driven into cycle N is read on the pr_* outputs in cycle N+1, because one register stage sits between them. The lk_stall high that pairs with a taken result is read in that same cycle. A lookup placed in the stall cycle is read as pr_valid low one cycle later. up_mispred is due one cycle after its update. Counter, history and buffer changes show up in the result of the next lookup driven after the update cycle. Every stimulus is applied on a falling edge, and every output is read on the following falling edge, half a cycle clear of the capturing edge. The dropped-lookup and untouched-history cases are checked through pr_valid and a later pr_ghist.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

   localparam logic [1:0] CTR_WEAK_NT = 2'b01;

   // saturating 2-bit counter step
   function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
      if (up)  return (c == 2'b11) ? c : c + 2'b01;
      else     return (c == 2'b00) ? c : c - 2'b01;
   endfunction

   // tree pseudo-LRU for four ways: bit0 picks the half, bit1/bit2 the way
   function automatic logic [1:0] tree_victim(input logic [2:0] t);
      if (t[0]) return t[2] ? 2'd3 : 2'd2;
      else      return t[1] ? 2'd1 : 2'd0;
   endfunction

   function automatic logic [2:0] tree_touch(input logic [2:0] t, input logic [1:0] w);
      logic [2:0] r;
      r = t;
      if (!w[1]) begin
         r[0] = 1'b1;
         r[1] = (w == 2'd0);
      end else begin
         r[0] = 1'b0;
         r[2] = (w == 2'd2);
      end
      return r;
   endfunction

endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
   parameter int GH_W = 12
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            spec_en,
   input  logic            spec_bit,
   input  logic            fix_en,
   input  logic [GH_W-1:0] fix_val,
   output logic [GH_W-1:0] hist
);

   generate
      if (GH_W < 2) begin : g_bad_width
         $error("bp_hist_reg: GH_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist <= '0;
      else if (fix_en)  hist <= fix_val;
      else if (spec_en) hist <= {hist[GH_W-2:0], spec_bit};
   end

endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table
   import brpred_pkg::*;
#(
   parameter int GH_W   = 12,
   parameter int LANE_W = 2
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [GH_W-1:0] rd_idx,
   output logic [1:0]      rd_ctr,
   input  logic            wr_en,
   input  logic [GH_W-1:0] wr_idx,
   input  logic            wr_taken
);

   localparam int CPR   = 1 << LANE_W;          // counters per row
   localparam int ROWS  = (1 << GH_W) / CPR;
   localparam int ROW_W = 2 * CPR;

   generate
      if (GH_W <= LANE_W) begin : g_bad_depth
         $error("bp_dir_table: GH_W must exceed LANE_W");
      end
   endgenerate

   logic [ROW_W-1:0] row_q [ROWS];
   logic [1:0]       wr_cur;

   assign rd_ctr = row_q[rd_idx[GH_W-1:LANE_W]][{rd_idx[LANE_W-1:0], 1'b0} +: 2];
   assign wr_cur = row_q[wr_idx[GH_W-1:LANE_W]][{wr_idx[LANE_W-1:0], 1'b0} +: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) row_q[r] <= {CPR{CTR_WEAK_NT}};
      end else if (wr_en) begin
         row_q[wr_idx[GH_W-1:LANE_W]][{wr_idx[LANE_W-1:0], 1'b0} +: 2] <= ctr_step(wr_cur, wr_taken);
      end
   end

endmodule

// File: rtl/bp_tgt_buf.sv
module bp_tgt_buf
   import brpred_pkg::*;
#(
   parameter int PC_W = 32,
   parameter int SETS = 32,
   parameter int WAYS = 4
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_hit,
   output logic [PC_W-1:0] rd_tgt,
   input  logic            wr_req,
   input  logic [PC_W-1:0] wr_pc,
   input  logic            wr_taken,
   input  logic [PC_W-1:0] wr_tgt
);

   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = PC_W - SET_W - 2;

   generate
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("bp_tgt_buf: WAYS must be a power of two, at least 2");
      end
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("bp_tgt_buf: SETS must be a power of two, at least 2");
      end
   endgenerate

   logic                v_q   [SETS][WAYS];
   logic [TAG_W-1:0]    tag_q [SETS][WAYS];
   logic [PC_W-1:0]     tgt_q [SETS][WAYS];

   logic [SET_W-1:0]    rs, us;
   logic [TAG_W-1:0]    rt, ut;
   logic                u_hit, free_any, do_wr;
   logic [WAY_W-1:0]    u_way, free_way, victim, wr_way;

   assign rs = rd_pc[SET_W+1:2];
   assign rt = rd_pc[PC_W-1:SET_W+2];
   assign us = wr_pc[SET_W+1:2];
   assign ut = wr_pc[PC_W-1:SET_W+2];

   always_comb begin
      rd_hit = 1'b0;
      rd_tgt = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (v_q[rs][w] && tag_q[rs][w] == rt) begin
            rd_hit = 1'b1;
            rd_tgt = tgt_q[rs][w];
         end
      end
   end

   always_comb begin
      u_hit    = 1'b0;
      u_way    = '0;
      free_any = 1'b0;
      free_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (v_q[us][w] && tag_q[us][w] == ut) begin
            u_hit = 1'b1;
            u_way = WAY_W'(w);
         end
      end
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!v_q[us][w]) begin
            free_any = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

   assign do_wr  = wr_req & wr_taken;
   assign wr_way = u_hit ? u_way : (free_any ? free_way : victim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) v_q[s][w] <= 1'b0;
      end else if (do_wr) begin
         v_q[us][wr_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) begin
         tag_q[us][wr_way] <= ut;
         tgt_q[us][wr_way] <= wr_tgt;
      end
   end

   generate
      if (WAYS == 4) begin : g_tree
         logic [2:0] tree_q [SETS];
         assign victim = tree_victim(tree_q[us]);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
            end else if (do_wr) begin
               tree_q[us] <= tree_touch(tree_q[us], wr_way);
            end
         end
      end else begin : g_rr
         logic [WAY_W-1:0] rr_q [SETS];
         assign victim = rr_q[us];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
            end else if (do_wr && !u_hit && !free_any) begin
               rr_q[us] <= rr_q[us] + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/brpred_top.sv
module brpred_top
   import brpred_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int GH_W    = 12,
   parameter int TB_SETS = 32,
   parameter int TB_WAYS = 4
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lk_valid,
   input  logic [PC_W-1:0] lk_pc,
   input  logic            lk_br,
   input  logic            lk_bwd,
   output logic            lk_stall,
   output logic            pr_valid,
   output logic            pr_taken,
   output logic            pr_hit,
   output logic [PC_W-1:0] pr_target,
   output logic [GH_W-1:0] pr_ghist,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken,
   input  logic [PC_W-1:0] up_target,
   input  logic [GH_W-1:0] up_ghist,
   input  logic            up_pred_tk,
   input  logic            up_pred_hit,
   input  logic [PC_W-1:0] up_pred_tgt,
   output logic            up_mispred
);

   generate
      if (PC_W < GH_W + 3) begin : g_bad_pc
         $error("brpred_top: PC_W too narrow for the table index");
      end
   endgenerate

   logic [GH_W-1:0] hist_q;
   logic            stall_q;
   logic            accept, guess, mis;
   logic [GH_W-1:0] rd_idx, wr_idx;
   logic [1:0]      rd_ctr;
   logic            tb_hit;
   logic [PC_W-1:0] tb_tgt;

   assign lk_stall = stall_q;
   assign accept   = lk_valid & lk_br & ~stall_q;
   assign rd_idx   = hist_q ^ lk_pc[GH_W+1:2];
   assign wr_idx   = up_ghist ^ up_pc[GH_W+1:2];
   assign guess    = tb_hit ? rd_ctr[1] : lk_bwd;
   assign mis      = (up_taken != up_pred_tk)
                   | (up_taken & up_pred_hit & (up_target != up_pred_tgt));

   bp_hist_reg #(.GH_W(GH_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .spec_en  (accept),
      .spec_bit (guess),
      .fix_en   (up_valid & mis),
      .fix_val  ({up_ghist[GH_W-2:0], up_taken}),
      .hist     (hist_q)
   );

   bp_dir_table #(.GH_W(GH_W)) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_ctr   (rd_ctr),
      .wr_en    (up_valid),
      .wr_idx   (wr_idx),
      .wr_taken (up_taken)
   );

   bp_tgt_buf #(.PC_W(PC_W), .SETS(TB_SETS), .WAYS(TB_WAYS)) u_tgt (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_pc    (lk_pc),
      .rd_hit   (tb_hit),
      .rd_tgt   (tb_tgt),
      .wr_req   (up_valid),
      .wr_pc    (up_pc),
      .wr_taken (up_taken),
      .wr_tgt   (up_target)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pr_valid   <= 1'b0;
         pr_taken   <= 1'b0;
         pr_hit     <= 1'b0;
         pr_target  <= '0;
         pr_ghist   <= '0;
         stall_q    <= 1'b0;
         up_mispred <= 1'b0;
      end else begin
         pr_valid   <= accept;
         stall_q    <= accept & guess;
         up_mispred <= up_valid & mis;
         if (accept) begin
            pr_taken  <= guess;
            pr_hit    <= tb_hit;
            pr_target <= tb_hit ? tb_tgt : '0;
            pr_ghist  <= hist_q;
         end
      end
   end

endmodule

// File: rtl/brpred_chk.sv
module brpred_chk #(
   parameter int GH_W = 12
)(
   input logic            clk,
   input logic            rst_n,
   input logic            lk_valid,
   input logic            lk_br,
   input logic            lk_bwd,
   input logic            lk_stall,
   input logic            pr_valid,
   input logic            pr_taken,
   input logic            pr_hit,
   input logic            up_valid,
   input logic            up_taken,
   input logic [GH_W-1:0] up_ghist,
   input logic [GH_W-1:0] hist_q,
   input logic            up_mispred
);

   p_valid_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pr_valid |-> $past(lk_valid && lk_br && !lk_stall));

   p_static_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_valid && !pr_hit) |-> (pr_taken == $past(lk_bwd)));

   p_taken_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_valid && pr_taken) |-> lk_stall);

   p_stall_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_stall |=> (!pr_valid && !lk_stall));

   p_mispred_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      up_mispred |-> $past(up_valid));

   p_hist_repair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      up_mispred |-> (hist_q == {$past(up_ghist[GH_W-2:0]), $past(up_taken)}));

endmodule

bind brpred_top brpred_chk #(.GH_W(GH_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_br      (lk_br),
   .lk_bwd     (lk_bwd),
   .lk_stall   (lk_stall),
   .pr_valid   (pr_valid),
   .pr_taken   (pr_taken),
   .pr_hit     (pr_hit),
   .up_valid   (up_valid),
   .up_taken   (up_taken),
   .up_ghist   (up_ghist),
   .hist_q     (hist_q),
   .up_mispred (up_mispred)
);

// File: tb/sim_brpred_top.sv
module sim_brpred_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0, lk_br = 1'b0, lk_bwd = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_stall, pr_valid, pr_taken, pr_hit, up_mispred;
   logic [31:0] pr_target;
   logic [11:0] pr_ghist;
   logic        up_valid = 1'b0, up_taken = 1'b0, up_pred_tk = 1'b0, up_pred_hit = 1'b0;
   logic [31:0] up_pc = '0, up_target = '0, up_pred_tgt = '0;
   logic [11:0] up_ghist = '0;

   int n_chk = 0;
   int n_err = 0;

   always #2ns clk = ~clk;

   brpred_top u0 (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_br(lk_br), .lk_bwd(lk_bwd), .lk_stall(lk_stall),
      .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_hit(pr_hit), .pr_target(pr_target),
      .pr_ghist(pr_ghist),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target),
      .up_ghist(up_ghist), .up_pred_tk(up_pred_tk), .up_pred_hit(up_pred_hit),
      .up_pred_tgt(up_pred_tgt), .up_mispred(up_mispred)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // drive one lookup; returns at the falling edge where its result is readable
   task automatic look(input logic [31:0] pc, input logic bwd);
      @(negedge clk);
      lk_valid = 1'b1; lk_br = 1'b1; lk_pc = pc; lk_bwd = bwd;
      @(negedge clk);
      lk_valid = 1'b0; lk_br = 1'b0;
   endtask

   // drive one update; returns where up_mispred is readable
   task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                      input logic [11:0] gh, input logic ptk, input logic phit,
                      input logic [31:0] ptgt);
      @(negedge clk);
      up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tgt; up_ghist = gh;
      up_pred_tk = ptk; up_pred_hit = phit; up_pred_tgt = ptgt;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "pr_valid", pr_valid, 0);
      chk("R1", "lk_stall", lk_stall, 0);
      chk("R1", "up_mispred", up_mispred, 0);
   endtask

   task automatic t_static_throttle;
      @(negedge clk);
      lk_valid = 1; lk_br = 1; lk_pc = 32'h100; lk_bwd = 1;
      @(negedge clk);
      chk("R2", "valid after lookup", pr_valid, 1);
      chk("R4", "miss hit flag", pr_hit, 0);
      chk("R4", "backward miss taken", pr_taken, 1);
      chk("R1", "history at reset", pr_ghist, 12'h000);
      chk("R5", "stall with taken", lk_stall, 1);
      lk_pc = 32'h200; lk_bwd = 0;                 // lands in the bubble
      @(negedge clk);
      chk("R5", "bubble lookup dropped", pr_valid, 0);
      chk("R5", "stall lasts one cycle", lk_stall, 0);
      lk_br = 0;                                   // not a branch
      @(negedge clk);
      chk("R2", "non-branch gives no result", pr_valid, 0);
      lk_br = 1;
      @(negedge clk);
      chk("R5", "first back-to-back valid", pr_valid, 1);
      chk("R4", "forward miss not taken", pr_taken, 0);
      chk("R6", "history after taken guess", pr_ghist, 12'h001);
      lk_pc = 32'h204;
      @(negedge clk);
      chk("R5", "second back-to-back valid", pr_valid, 1);
      chk("R6", "history after not-taken guess", pr_ghist, 12'h002);
      lk_valid = 0; lk_br = 0;
   endtask

   task automatic t_mispredict_repair;
      upd(32'h300, 1, 32'h480, 12'h0A5, 0, 0, 32'h0);
      chk("R8", "direction mispredict", up_mispred, 1);
      look(32'h300, 0);
      chk("R10", "taken update allocated", pr_hit, 1);
      chk("R3", "hit target", pr_target, 32'h480);
      chk("R9", "history rebuilt from checkpoint", pr_ghist, 12'h14B);
      chk("R1", "untouched counter weakly not taken", pr_taken, 0);
      upd(32'h500, 0, 32'h0, 12'h123, 0, 0, 32'h0);
      chk("R8", "correct guess no flag", up_mispred, 0);
      look(32'h500, 0);
      chk("R10", "not-taken update no allocation", pr_hit, 0);
      chk("R9", "history kept on correct guess", pr_ghist, 12'h296);
   endtask

   task automatic t_counter_train;
      upd(32'h300, 1, 32'h480, 12'h000, 1, 1, 32'h480);
      chk("R8", "correct taken no flag", up_mispred, 0);
      upd(32'h040, 0, 32'h0, 12'h000, 1, 0, 32'h0);   // repair history to 0
      chk("R8", "not-taken vs taken guess", up_mispred, 1);
      look(32'h300, 0);
      chk("R7", "counter up to strongish taken", pr_taken, 1);
      chk("R3", "hit with trained counter", pr_hit, 1);
      chk("R6", "history after repair", pr_ghist, 12'h000);
      upd(32'h300, 1, 32'h480, 12'h000, 1, 1, 32'h480);
      upd(32'h300, 1, 32'h480, 12'h000, 1, 1, 32'h480);   // saturates at 3
      upd(32'h300, 0, 32'h480, 12'h000, 1, 1, 32'h480);
      upd(32'h300, 0, 32'h480, 12'h000, 1, 1, 32'h480);
      chk("R8", "flag on not-taken outcome", up_mispred, 1);
      look(32'h300, 0);
      chk("R7", "saturated counter back to 1", pr_taken, 0);
      chk("R10", "entry kept after not-taken", pr_hit, 1);
   endtask

   task automatic t_target_refresh;
      upd(32'h300, 1, 32'h600, 12'h000, 1, 1, 32'h480);
      chk("R8", "target mismatch flag", up_mispred, 1);
      look(32'h300, 0);
      chk("R12", "target refreshed", pr_target, 32'h600);
      chk("R9", "history after target mispredict", pr_ghist, 12'h001);
      chk("R3", "direction from fresh index", pr_taken, 0);
   endtask

   task automatic t_replacement;
      for (int k = 0; k < 5; k++)
         upd(32'h1014 + 32'(k) * 32'h80, 1, 32'h2000 + 32'(k) * 4, 12'h000, 1, 0, 32'h0);
      chk("R8", "miss-taken correct guess no flag", up_mispred, 0);
      look(32'h1014, 0);
      chk("R11", "first-filled way evicted", pr_hit, 0);
      look(32'h1214, 0);
      chk("R11", "fifth entry present", pr_hit, 1);
      chk("R11", "fifth entry target", pr_target, 32'h2010);
      look(32'h1094, 0);
      chk("R10", "second entry kept", pr_target, 32'h2004);
      look(32'h1194, 0);
      chk("R10", "fourth entry kept", pr_target, 32'h200C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_static_throttle();
      t_mispredict_repair();
      t_counter_train();
      t_target_refresh();
      t_replacement();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule